// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a load or store and decides whether the base register gets a new value. A caller presents a base value, an offset source (a zero-extended immediate, a general register, or a general register put through a shift), an add/subtract direction, an indexing mode and an access size. It then raises a one-cycle start strobe. One cycle later the block presents the effective address, a writeback enable and value for the base register, and an illegal-encoding flag. A one-cycle done strobe accompanies them.

Three indexing modes exist. In offset mode the base is left alone. In pre-indexed mode the computed address is both used and written back. In post-indexed mode the raw base is used and the computed address is written back. The access size limits the immediate width and decides whether a shifted register offset is allowed. The offset register may never be register 15, which is the program counter. The base register may be the program counter. All arithmetic wraps modulo 2^32. The block performs no memory access and no register-file write itself.

Top module: `ls_agu_top`

## Requirements
- R1: With idxMode=0 (offset), effAddr equals base plus or minus the offset, wbEn is 0 and wbVal is 0.
- R2: With idxMode=1 (pre-indexed), effAddr equals base plus or minus the offset, wbEn is 1 and wbVal equals effAddr.
- R3: With idxMode=2 (post-indexed), effAddr equals the unmodified base, wbEn is 1 and wbVal equals base plus or minus the offset.
- R4: subtract=1 subtracts the offset from the base and subtract=0 adds it. Both operations wrap modulo 2^32.
- R5: offKind selects the offset source: 0 is the immediate (zero-extended), 1 is offReg, 2 is offReg shifted, and 3 is reserved and illegal.
- R6: For accSize 0 (word) and 1 (unsigned byte) the immediate is immVal[11:0]. For accSize 2 (halfword) and 3 (signed byte) it is immVal[7:0], and immVal[11:8] is ignored.
- R7: For offKind=2, shiftType selects the shift of offReg by shiftAmt (0 to 31): 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. For other kinds, shiftType and shiftAmt are ignored.
- R8: The request is illegal in any of these cases: offKind=2 with accSize 2 or 3; offRegIdx=15 with offKind 1 or 2; offKind=3; idxMode=3. An illegal request gives illegal=1, wbEn=0, effAddr=0 and wbVal=0. offRegIdx is ignored when offKind=0.
- R9: Outputs update on the clock edge that samples start=1, and done is high for exactly that following cycle. Without start, the outputs hold their values. Back-to-back starts each produce their own result.
- R10: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| baseVal | input | 32 | Base register value |
| offReg | input | 32 | Offset register value |
| offRegIdx | input | 4 | Offset register index |
| immVal | input | 12 | Immediate offset |
| offKind | input | 2 | Offset source select |
| shiftType | input | 2 | Shift kind for scaled offset |
| shiftAmt | input | 5 | Shift amount |
| subtract | input | 1 | 1 subtracts offset, 0 adds |
| idxMode | input | 2 | 0 offset, 1 pre, 2 post |
| accSize | input | 2 | 0 word, 1 ubyte, 2 half, 3 sbyte |
| effAddr | output | 32 | Effective address |
| wbEn | output | 1 | Base writeback enable |
| wbVal | output | 32 | Base writeback value |
| illegal | output | 1 | Illegal encoding flag |
| done | output | 1 | Result-valid strobe |

## Verification
The effective address and the base writeback value are produced in the same cycle from one adder result. The bench must therefore tell pre-indexed from post-indexed use of that result. It does this with bases and offsets chosen so that the base and the sum always differ, and it checks both outputs in the single done cycle. Illegal decoding also lands in that cycle and has to suppress the writeback that the mode would otherwise request. Pre-indexed requests with an excluded offset register are checked for wbEn=0 alongside the flag. Back-to-back starts confirm that each done cycle carries its own request's address and writeback.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  typedef enum logic [1:0] {MODE_OFFSET = 2'd0, MODE_PRE = 2'd1, MODE_POST = 2'd2, MODE_RSVD = 2'd3} idxMode_e;
  typedef enum logic [1:0] {OFF_IMM = 2'd0, OFF_REG = 2'd1, OFF_SCALED = 2'd2, OFF_RSVD = 2'd3} offKind_e;
  typedef enum logic [1:0] {SZ_WORD = 2'd0, SZ_UBYTE = 2'd1, SZ_HALF = 2'd2, SZ_SBYTE = 2'd3} accSize_e;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3} shType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic useReg;
    logic useShift;
    logic narrowImm;
    logic addrFromSum;
    logic wbReq;
    logic illegal;
  } ctrlStrobe_t;
endpackage

// File: rtl/ls_agu_ctrl.sv
module ls_agu_ctrl
  import ls_agu_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           offKind,
  input  logic [1:0]           idxMode,
  input  logic [1:0]           accSize,
  input  logic [REG_IDX_W-1:0] offRegIdx,
  output ctrlStrobe_t          st,
  output logic                 done
);
  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  logic narrowSize;
  logic usesReg;
  logic badEnc;

  always_comb begin
    narrowSize = (accSize == SZ_HALF) || (accSize == SZ_SBYTE);
    usesReg    = (offKind == OFF_REG) || (offKind == OFF_SCALED);
    badEnc     = (offKind == OFF_RSVD) || (idxMode == MODE_RSVD)
              || ((offKind == OFF_SCALED) && narrowSize)
              || (usesReg && (offRegIdx == PC_CODE));

    st.capture     = start;
    st.useReg      = usesReg;
    st.useShift    = (offKind == OFF_SCALED);
    st.narrowImm   = narrowSize;
    st.addrFromSum = (idxMode != MODE_POST);
    st.wbReq       = ((idxMode == MODE_PRE) || (idxMode == MODE_POST)) && !badEnc;
    st.illegal     = badEnc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end
endmodule

// File: rtl/ls_agu_dp.sv
module ls_agu_dp
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IMM_W        = 12,
  parameter int IMM_NARROW_W = 8,
  parameter int SH_W         = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       st,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offReg,
  input  logic [IMM_W-1:0]  immVal,
  input  logic [1:0]        shiftType,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic              subtract,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal,
  output logic              illegal
);
  logic [ADDR_W-1:0]   immExt;
  logic [ADDR_W-1:0]   shifted;
  logic [2*ADDR_W-1:0] rotPair;
  logic [ADDR_W-1:0]   offVal;
  logic [ADDR_W-1:0]   sum;

  always_comb begin
    immExt  = st.narrowImm ? ADDR_W'(immVal[IMM_NARROW_W-1:0]) : ADDR_W'(immVal);
    rotPair = {offReg, offReg} >> shiftAmt;
    unique case (shType_e'(shiftType))
      SH_LSL:  shifted = offReg << shiftAmt;
      SH_LSR:  shifted = offReg >> shiftAmt;
      SH_ASR:  shifted = ADDR_W'($signed(offReg) >>> shiftAmt);
      default: shifted = rotPair[ADDR_W-1:0];
    endcase
    if (!st.useReg)      offVal = immExt;
    else if (st.useShift) offVal = shifted;
    else                 offVal = offReg;
    sum = subtract ? (baseVal - offVal) : (baseVal + offVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr <= '0;
      wbEn    <= 1'b0;
      wbVal   <= '0;
      illegal <= 1'b0;
    end else if (st.capture) begin
      if (st.illegal) begin
        effAddr <= '0;
        wbEn    <= 1'b0;
        wbVal   <= '0;
        illegal <= 1'b1;
      end else begin
        effAddr <= st.addrFromSum ? sum : baseVal;
        wbEn    <= st.wbReq;
        wbVal   <= st.wbReq ? sum : '0;
        illegal <= 1'b0;
      end
    end
  end

  // results hold while no request is taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> ($stable(effAddr) && $stable(wbVal) && $stable(wbEn)));
  // an illegal flag never travels with a writeback
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wbEn && effAddr == '0 && wbVal == '0));
endmodule

// File: rtl/ls_agu_top.sv
module ls_agu_top
  import ls_agu_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IMM_W        = 12,
  parameter int IMM_NARROW_W = 8,
  parameter int REG_IDX_W    = 4,
  parameter int PC_IDX       = 15,
  localparam int SH_W        = $clog2(ADDR_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [ADDR_W-1:0]    offReg,
  input  logic [REG_IDX_W-1:0] offRegIdx,
  input  logic [IMM_W-1:0]     immVal,
  input  logic [1:0]           offKind,
  input  logic [1:0]           shiftType,
  input  logic [SH_W-1:0]      shiftAmt,
  input  logic                 subtract,
  input  logic [1:0]           idxMode,
  input  logic [1:0]           accSize,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 wbEn,
  output logic [ADDR_W-1:0]    wbVal,
  output logic                 illegal,
  output logic                 done
);
  ctrlStrobe_t st;

  ls_agu_ctrl #(.REG_IDX_W(REG_IDX_W), .PC_IDX(PC_IDX)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .offKind(offKind), .idxMode(idxMode),
    .accSize(accSize), .offRegIdx(offRegIdx), .st(st), .done(done)
  );

  ls_agu_dp #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .IMM_NARROW_W(IMM_NARROW_W), .SH_W(SH_W)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .baseVal(baseVal), .offReg(offReg), .immVal(immVal),
    .shiftType(shiftType), .shiftAmt(shiftAmt), .subtract(subtract),
    .effAddr(effAddr), .wbEn(wbEn), .wbVal(wbVal), .illegal(illegal)
  );

  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
  p_offset_no_wb_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && idxMode == MODE_OFFSET) |=> !wbEn);
  p_pre_same_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && idxMode == MODE_PRE) |=> (illegal || (wbEn && wbVal == effAddr)));
  p_post_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && idxMode == MODE_POST) |=> (illegal || effAddr == $past(baseVal)));
  p_reserved_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && idxMode == MODE_RSVD) |=> illegal);
endmodule

// File: tb/ls_agu_tb_top.sv
module ls_agu_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseVal = '0, offReg = '0;
  logic [3:0]  offRegIdx = '0;
  logic [11:0] immVal = '0;
  logic [1:0]  offKind = '0, shiftType = '0, idxMode = '0, accSize = '0;
  logic [4:0]  shiftAmt = '0;
  logic        subtract = 1'b0;
  logic [31:0] effAddr, wbVal;
  logic        wbEn, illegal, done;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  ls_agu_top dut_i (.*);

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] oreg;
    logic [3:0]  idx;
    logic [11:0] imm;
    logic [1:0]  kind;
    logic [1:0]  sh;
    logic [4:0]  amt;
    logic        sub;
    logic [1:0]  mode;
    logic [1:0]  size;
    logic [31:0] expA;
    logic        expWb;
    logic [31:0] expV;
    logic        expIll;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h0, 4'd1, 12'h004, 2'd0, 2'd0, 5'd0, 1'b0, 2'd0, 2'd0, 32'h1004, 1'b0, 32'h0, 1'b0, 4'd1},          // R1
    '{32'h2000, 32'h0, 4'd1, 12'hFFF, 2'd0, 2'd0, 5'd0, 1'b0, 2'd1, 2'd0, 32'h2FFF, 1'b1, 32'h2FFF, 1'b0, 4'd2},       // R2
    '{32'h3000, 32'h10, 4'd2, 12'h0, 2'd1, 2'd0, 5'd0, 1'b0, 2'd2, 2'd0, 32'h3000, 1'b1, 32'h3010, 1'b0, 4'd3},        // R3
    '{32'h4, 32'h0, 4'd0, 12'h008, 2'd0, 2'd0, 5'd0, 1'b1, 2'd0, 2'd0, 32'hFFFFFFFC, 1'b0, 32'h0, 1'b0, 4'd4},         // R4
    '{32'hFFFFFFF0, 32'h20, 4'd3, 12'h0, 2'd1, 2'd0, 5'd0, 1'b0, 2'd1, 2'd0, 32'h10, 1'b1, 32'h10, 1'b0, 4'd4},       // R4
    '{32'h100, 32'h0, 4'd0, 12'hF05, 2'd0, 2'd0, 5'd0, 1'b0, 2'd0, 2'd2, 32'h105, 1'b0, 32'h0, 1'b0, 4'd6},           // R6
    '{32'h1000, 32'h3, 4'd4, 12'h0, 2'd2, 2'd0, 5'd2, 1'b0, 2'd0, 2'd0, 32'h100C, 1'b0, 32'h0, 1'b0, 4'd7},           // R7 LSL
    '{32'h0, 32'h100, 4'd4, 12'h0, 2'd2, 2'd1, 5'd4, 1'b0, 2'd0, 2'd1, 32'h10, 1'b0, 32'h0, 1'b0, 4'd7},              // R7 LSR
    '{32'h0, 32'h80000000, 4'd5, 12'h0, 2'd2, 2'd2, 5'd4, 1'b0, 2'd0, 2'd0, 32'hF8000000, 1'b0, 32'h0, 1'b0, 4'd7},   // R7 ASR
    '{32'h1, 32'hAB, 4'd5, 12'h0, 2'd2, 2'd3, 5'd8, 1'b0, 2'd0, 2'd0, 32'hAB000001, 1'b0, 32'h0, 1'b0, 4'd7},         // R7 ROR
    '{32'h500, 32'h4, 4'd6, 12'h0, 2'd2, 2'd0, 5'd1, 1'b0, 2'd1, 2'd2, 32'h0, 1'b0, 32'h0, 1'b1, 4'd8},               // R8 scaled half
    '{32'h600, 32'h4, 4'd15, 12'h0, 2'd1, 2'd0, 5'd0, 1'b0, 2'd1, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 4'd8},              // R8 reg 15
    '{32'h50, 32'h0, 4'd15, 12'h010, 2'd0, 2'd3, 5'd7, 1'b0, 2'd0, 2'd0, 32'h60, 1'b0, 32'h0, 1'b0, 4'd8},            // R8 idx ignored, R7 amt ignored
    '{32'h700, 32'h0, 4'd0, 12'h004, 2'd0, 2'd0, 5'd0, 1'b0, 2'd3, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 4'd8},             // R8 reserved mode
    '{32'h800, 32'h4, 4'd2, 12'h004, 2'd3, 2'd0, 5'd0, 1'b0, 2'd2, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 4'd5},             // R5 reserved kind
    '{32'h200, 32'h0, 4'd0, 12'h1FF, 2'd0, 2'd0, 5'd0, 1'b1, 2'd1, 2'd3, 32'h101, 1'b1, 32'h101, 1'b0, 4'd6}          // R6 sbyte
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    baseVal = v.base; offReg = v.oreg; offRegIdx = v.idx; immVal = v.imm;
    offKind = v.kind; shiftType = v.sh; shiftAmt = v.amt; subtract = v.sub;
    idxMode = v.mode; accSize = v.size;
  endtask

  task automatic checkRes(input string tag, input vec_t v);
    chk({tag, " effAddr"}, effAddr, v.expA);
    chk({tag, " wbEn"}, 32'(wbEn), 32'(v.expWb));
    chk({tag, " wbVal"}, wbVal, v.expV);
    chk({tag, " illegal"}, 32'(illegal), 32'(v.expIll));
    chk({tag, " done"}, 32'(done), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset effAddr", effAddr, 32'h0);
    chk("R10 reset wbVal", wbVal, 32'h0);
    chk("R10 reset flags", {28'h0, wbEn, illegal, done, 1'b0}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [31:0] held;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      drive(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      checkRes(tag, VECS[i]);
      held = effAddr;
      // R9: other inputs change, no start -> outputs hold, done drops
      baseVal = ~baseVal;
      @(negedge clk);
      chk($sformatf("R9 hold vec%0d done", i), 32'(done), 32'd0);
      chk($sformatf("R9 hold vec%0d effAddr", i), effAddr, held);
    end

    // R9: back-to-back starts
    drive(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    checkRes("R9 b2b first", VECS[0]);
    drive(VECS[2]);
    @(negedge clk);
    start = 1'b0;
    checkRes("R9 b2b second", VECS[2]);
    @(negedge clk);
    chk("R9 b2b done drop", 32'(done), 32'd0);

    // R10: reset clears results
    drive(VECS[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk("R10 mid reset effAddr", effAddr, 32'h0);
    chk("R10 mid reset wb", {31'h0, wbEn}, 32'h0);
    chk("R10 mid reset wbVal", wbVal, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule